// File: doc/BRIEF.md
# Bridge Interrupt Control and Status

This block collects the interrupt sources of a host-to-local bus bridge and steers them to two active-low lines: one towards the host and one towards the local side. Software sees a single 32-bit control and status word. The enable bits in this word are writable. The flags in it are read-only and show which enabled sources are currently active. Every interrupt is derived from the present level of its own source, so an interrupt goes away only when its cause is removed. The exceptions are the two DMA channel events. Each of these is held until its clear pulse arrives.

The block also counts consecutive master retries to one target. When retry limiting is on, it turns a long run of retries into a one-cycle abort indication. The bridge logic around the block keeps the doorbell registers, the abort status, the DMA engines and the bus protocol. It presents their state on the source inputs and reads the word through a plain register port.

Top module: `bic_top`

## Requirements
- R1: After reset the word reads 0x0001_0000 when no source is active, and both `host_irq_n` and `lint_out_n` are 1.
- R2: A write stores only the enable bits 8–12 and 16–19. Writes to every other bit, the read-only flags 13–15 and 20–23 among them, have no effect.
- R3: Flag bit 13 reads 1 exactly when enable bit 9 is 1 and at least one bit of `l2h_bell` is 1. This source is routed to the host line.
- R4: Flag bit 14 reads 1 exactly when enable bit 10 is 1 and `mst_abort` or `tgt_abort` is 1. This source is routed to the host line.
- R5: Flag bit 15 reads 1 exactly when enable bit 11 is 1 and `lint_in_n` is 0. Nothing is latched, so raising the input removes the flag at once. This source is routed to the host line.
- R6: Flag bit 20 reads 1 exactly when enable bit 17 is 1 and at least one bit of `h2l_bell` is 1. This source is routed to the local line.
- R7: A `dma_done[i]` pulse sets a pending state for channel i, and a `dma_clr[i]` pulse clears it. When both arrive together, the clear wins. Flag bit 21+i reads enable bit 18+i AND pending. `dma_sel[i]`=1 routes the channel to the host line, and 0 routes it to the local line.
- R8: Flag bit 23 follows `bist_en` with no enable bit of its own. It is routed to the host line.
- R9: `host_irq_n` is 0 in the cycle after the one in which bit 8 is 1 and any host-routed flag is 1. Otherwise it is 1. `lint_out_n` behaves the same way, using bit 16 and the local-routed flags.
- R10: With bit 12 = 1, the 256th consecutive retry response (`rsp_valid`=1, `rsp_retry`=1) to one `rsp_tgt` makes `retry_abort` 1 for one cycle, in the following cycle, and the count then starts again. A non-retry response restarts the count at 0. A retry to a different target restarts the count at 1.
- R11: With bit 12 = 0, `retry_abort` stays 0 regardless of the number of retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control and status word |
| l2h_bell | input | DB_W | Local-to-host doorbell contents |
| h2l_bell | input | DB_W | Host-to-local doorbell contents |
| mst_abort | input | 1 | Master abort status flag |
| tgt_abort | input | 1 | Detected target abort status flag |
| lint_in_n | input | 1 | Active-low local interrupt input |
| dma_done | input | 2 | Per-channel DMA completion pulse |
| dma_clr | input | 2 | Per-channel DMA interrupt clear pulse |
| dma_sel | input | 2 | Per-channel routing select, 1 = host |
| bist_en | input | 1 | Self-test interrupt enable level |
| rsp_valid | input | 1 | A master response is reported |
| rsp_retry | input | 1 | The reported response is a retry |
| rsp_tgt | input | TGT_W | Target identifier of the response |
| retry_abort | output | 1 | One-cycle retry-limit abort |
| host_irq_n | output | 1 | Active-low host interrupt |
| lint_out_n | output | 1 | Active-low local interrupt output |

## Verification
The assertions check four things on every cycle. A cleared master enable holds its line high on the next cycle. An enabled local input with the host enable set pulls the host line low on the next cycle. A raised local input never leaves its flag set. A DMA clear always leaves that channel's flag at 0. They also check that an abort pulse always follows a retry response and never appears while retry limiting is off.

Some behaviour can only be shown by the bench scenarios. These are the exact value of every flag for each combination of sources and enables, and the write mask. Others are the DMA set/clear priority and routing. The last is the exact count of 256, including the restarts on a non-retry response and on a target change.

// File: rtl/bic_pkg.sv
// Package: bit positions, write mask and reset value of the control word.
// Assumes the word layout is fixed; widths of sources are parameters elsewhere.
package bic_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_DMA     = 2;
    localparam int EN_HOST     = 8;
    localparam int EN_UPBELL   = 9;
    localparam int EN_ABORT    = 10;
    localparam int EN_LIN      = 11;
    localparam int EN_RETRY    = 12;
    localparam int ACT_UPBELL  = 13;
    localparam int ACT_ABORT   = 14;
    localparam int ACT_LIN     = 15;
    localparam int EN_LOCAL    = 16;
    localparam int EN_DNBELL   = 17;
    localparam int EN_DMA0     = 18;
    localparam int ACT_DNBELL  = 20;
    localparam int ACT_DMA0    = 21;
    localparam int ACT_SELF    = 23;
    localparam logic [WORD_W-1:0] WR_MASK  = 32'h000F_1F00;
    localparam logic [WORD_W-1:0] RST_WORD = 32'h0001_0000;
endpackage

// File: rtl/bic_ctrl_reg.sv
// Module: holds the writable enable bits of the control word.
// Assumes a single-cycle write strobe; bits outside the mask always read 0.
module bic_ctrl_reg
    import bic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl
);
    // Store masked write data; reset enables only the local output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= RST_WORD;
        else if (wr)
            ctrl <= wdata & WR_MASK;
    end
endmodule

// File: rtl/bic_dma_pend.sv
// Module: per-channel DMA interrupt pending state.
// Assumes done and clear are single-cycle pulses; a clear wins over a done.
module bic_dma_pend #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] done,
    input  logic [N_CH-1:0] clr,
    output logic [N_CH-1:0] pend
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Set on completion, drop on clear, clear has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (clr[i])
                pend[i] <= 1'b0;
            else if (done[i])
                pend[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/bic_retry_cnt.sv
// Module: counts consecutive retry responses to one target and emits a
// one-cycle abort when LIMIT is reached. Assumes at most one response per cycle.
module bic_retry_cnt #(
    parameter int LIMIT = 256,
    parameter int TGT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rsp_valid,
    input  logic             rsp_retry,
    input  logic [TGT_W-1:0] rsp_tgt,
    output logic             abort
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0]    cnt, cnt_nx;
    logic [TGT_W-1:0] last_tgt, tgt_nx;
    logic             hit;

    // Next count: restart on non-retry or new target, wrap at the limit.
    always_comb begin
        cnt_nx = cnt;
        tgt_nx = last_tgt;
        hit    = 1'b0;
        if (!en) begin
            cnt_nx = '0;
        end else if (rsp_valid) begin
            if (!rsp_retry) begin
                cnt_nx = '0;
            end else begin
                tgt_nx = rsp_tgt;
                if (cnt != '0 && rsp_tgt == last_tgt)
                    cnt_nx = cnt + CW'(1);
                else
                    cnt_nx = CW'(1);
                if (cnt_nx == CW'(LIMIT)) begin
                    hit    = 1'b1;
                    cnt_nx = '0;
                end
            end
        end
    end

    // Register count, last target and the abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            last_tgt <= '0;
            abort    <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            last_tgt <= tgt_nx;
            abort    <= hit;
        end
    end
endmodule

// File: rtl/bic_route.sv
// Module: derives the read-only active flags from source levels and enables,
// and drives the registered active-low host and local lines.
// Assumes source inputs are synchronous to clk.
module bic_route
    import bic_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  ctrl,
    input  logic [DB_W-1:0]    l2h_bell,
    input  logic [DB_W-1:0]    h2l_bell,
    input  logic               mst_abort,
    input  logic               tgt_abort,
    input  logic               lint_in_n,
    input  logic [NUM_DMA-1:0] dma_pend,
    input  logic [NUM_DMA-1:0] dma_sel,
    input  logic               bist_en,
    output logic [WORD_W-1:0]  status,
    output logic               host_irq_n,
    output logic               lint_out_n
);
    logic [NUM_DMA-1:0] dma_act;
    logic [NUM_DMA-1:0] dma_to_host, dma_to_local;
    logic               host_any, local_any;
    logic               unused_ctrl;

    assign unused_ctrl = ^{ctrl[7:0], ctrl[EN_RETRY], ctrl[31:20], ctrl[15:13]};

    for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma
        // Channel flag and its split to the two lines.
        assign dma_act[i]      = ctrl[EN_DMA0 + i] & dma_pend[i];
        assign dma_to_host[i]  = dma_act[i] & dma_sel[i];
        assign dma_to_local[i] = dma_act[i] & ~dma_sel[i];
    end

    // Assemble the read-only flags of the word.
    always_comb begin
        status             = '0;
        status[ACT_UPBELL] = ctrl[EN_UPBELL] & (|l2h_bell);
        status[ACT_ABORT]  = ctrl[EN_ABORT] & (mst_abort | tgt_abort);
        status[ACT_LIN]    = ctrl[EN_LIN] & ~lint_in_n;
        status[ACT_DNBELL] = ctrl[EN_DNBELL] & (|h2l_bell);
        status[ACT_SELF]   = bist_en;
        for (int i = 0; i < NUM_DMA; i++)
            status[ACT_DMA0 + i] = dma_act[i];
    end

    assign host_any  = status[ACT_UPBELL] | status[ACT_ABORT] | status[ACT_LIN]
                     | status[ACT_SELF] | (|dma_to_host);
    assign local_any = status[ACT_DNBELL] | (|dma_to_local);

    // Register both lines so they change only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_irq_n <= 1'b1;
            lint_out_n <= 1'b1;
        end else begin
            host_irq_n <= ~(ctrl[EN_HOST] & host_any);
            lint_out_n <= ~(ctrl[EN_LOCAL] & local_any);
        end
    end
endmodule

// File: rtl/bic_top.sv
// Module: bridge interrupt control and status top level.
// Assumes the surrounding bridge holds doorbell, abort and DMA state.
module bic_top
    import bic_pkg::*;
#(
    parameter int DB_W        = 8,
    parameter int TGT_W       = 4,
    parameter int RETRY_LIMIT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [DB_W-1:0]    l2h_bell,
    input  logic [DB_W-1:0]    h2l_bell,
    input  logic               mst_abort,
    input  logic               tgt_abort,
    input  logic               lint_in_n,
    input  logic [NUM_DMA-1:0] dma_done,
    input  logic [NUM_DMA-1:0] dma_clr,
    input  logic [NUM_DMA-1:0] dma_sel,
    input  logic               bist_en,
    input  logic               rsp_valid,
    input  logic               rsp_retry,
    input  logic [TGT_W-1:0]   rsp_tgt,
    output logic               retry_abort,
    output logic               host_irq_n,
    output logic               lint_out_n
);
    logic [WORD_W-1:0]  ctrl, status;
    logic [NUM_DMA-1:0] dma_pend;

    bic_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .ctrl(ctrl)
    );

    bic_dma_pend #(.N_CH(NUM_DMA)) u_dma (
        .clk(clk), .rst_n(rst_n), .done(dma_done), .clr(dma_clr), .pend(dma_pend)
    );

    bic_retry_cnt #(.LIMIT(RETRY_LIMIT), .TGT_W(TGT_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .en(ctrl[EN_RETRY]),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_tgt(rsp_tgt),
        .abort(retry_abort)
    );

    bic_route #(.DB_W(DB_W)) u_route (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .l2h_bell(l2h_bell), .h2l_bell(h2l_bell),
        .mst_abort(mst_abort), .tgt_abort(tgt_abort), .lint_in_n(lint_in_n),
        .dma_pend(dma_pend), .dma_sel(dma_sel), .bist_en(bist_en),
        .status(status), .host_irq_n(host_irq_n), .lint_out_n(lint_out_n)
    );

    // Read view: stored enables merged with live flags.
    assign reg_rdata = ctrl | status;
endmodule

// File: rtl/bic_chk.sv
// Module: assertion checker bound to bic_top; observes ports only.
module bic_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        lint_in_n,
    input logic [1:0]  dma_clr,
    input logic        rsp_valid,
    input logic        rsp_retry,
    input logic        retry_abort,
    input logic        host_irq_n,
    input logic        lint_out_n
);
    logic unused_rd;
    assign unused_rd = ^{reg_rdata[31:24], reg_rdata[20:17], reg_rdata[13:9], reg_rdata[7:0]};

    // R9: cleared host enable keeps the host line high next cycle
    a_r9_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[8] |=> host_irq_n);

    // R9: cleared local enable keeps the local line high next cycle
    a_r9_local_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[16] |=> lint_out_n);

    // R5: enabled local input with host enable pulls the host line low
    a_r5_lin_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[11] && reg_rdata[8] && !lint_in_n) |=> !host_irq_n);

    // R5: a high local input never shows its flag
    a_r5_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        lint_in_n |-> !reg_rdata[15]);

    // R7: a clear leaves the channel flags at 0
    a_r7_clr0: assert property (@(posedge clk) disable iff (!rst_n)
        dma_clr[0] |=> !reg_rdata[21]);
    a_r7_clr1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_clr[1] |=> !reg_rdata[22]);

    // R10: an abort pulse always follows a retry response
    a_r10_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
        retry_abort |-> $past(rsp_valid && rsp_retry));

    // R11: no abort while limiting is off
    a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[12] |=> !retry_abort);
endmodule

bind bic_top bic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .lint_in_n(lint_in_n),
    .dma_clr(dma_clr), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
    .retry_abort(retry_abort), .host_irq_n(host_irq_n), .lint_out_n(lint_out_n)
);

// File: tb/sim_bic_top.sv
// Bench: vector table for flag/routing combinations, then directed tests.
module sim_bic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [31:0] wdata;
        logic [7:0]  l2h;
        logic [7:0]  h2l;
        logic        mst;
        logic        tgt;
        logic        lin_n;
        logic [1:0]  sel;
        logic        bist;
        logic [31:0] exp_rd;
        logic        exp_host_n;
        logic        exp_lout_n;
    } vec_t;

    // wdata, l2h, h2l, mst, tgt, lin_n, sel, bist, exp_rd, exp_host_n, exp_lout_n
    localparam vec_t TBL [NVEC] = '{
        {32'h0000_0300, 8'h04, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0000_2300, 1'b0, 1'b1}, // R3 R9
        {32'h0000_0200, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0000_2200, 1'b1, 1'b1}, // R3 R9
        {32'h0000_0500, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0000_4500, 1'b0, 1'b1}, // R4
        {32'h0000_0900, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0000_8900, 1'b0, 1'b1}, // R5
        {32'h0003_0000, 8'h00, 8'h10, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0013_0000, 1'b1, 1'b0}, // R6
        {32'h0002_0000, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0012_0000, 1'b1, 1'b1}, // R6 R9
        {32'hFFFF_FFFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h000F_1F00, 1'b1, 1'b1}, // R2
        {32'h0000_0100, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 32'h0080_0100, 1'b0, 1'b1}, // R8
        {32'h0001_0000, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 32'h0081_0000, 1'b1, 1'b1}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  l2h_bell = '0, h2l_bell = '0;
    logic        mst_abort = 1'b0, tgt_abort = 1'b0, lint_in_n = 1'b1;
    logic [1:0]  dma_done = '0, dma_clr = '0, dma_sel = '0;
    logic        bist_en = 1'b0;
    logic        rsp_valid = 1'b0, rsp_retry = 1'b0;
    logic [3:0]  rsp_tgt = '0;
    logic        retry_abort, host_irq_n, lint_out_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bic_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .l2h_bell(l2h_bell), .h2l_bell(h2l_bell),
        .mst_abort(mst_abort), .tgt_abort(tgt_abort), .lint_in_n(lint_in_n),
        .dma_done(dma_done), .dma_clr(dma_clr), .dma_sel(dma_sel),
        .bist_en(bist_en), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
        .rsp_tgt(rsp_tgt), .retry_abort(retry_abort),
        .host_irq_n(host_irq_n), .lint_out_n(lint_out_n)
    );

    // Compare one value and report a miscompare.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock and return at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write the control word (called at a falling edge).
    task automatic wr_word(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // Issue n consecutive responses and count abort pulses seen.
    task automatic send_rsp(input int n, input logic retry, input logic [3:0] tgt, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            rsp_valid = 1'b1;
            rsp_retry = retry;
            rsp_tgt = tgt;
            tick();
            if (retry_abort) pulses++;
        end
        rsp_valid = 1'b0;
        rsp_retry = 1'b0;
        tick();
        if (retry_abort) pulses++;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 word", reg_rdata, 32'h0001_0000);
        chk("R1 host", {31'b0, host_irq_n}, 32'd1);
        chk("R1 local", {31'b0, lint_out_n}, 32'd1);

        // Table walk: flags, write mask and routing.
        for (int v = 0; v < NVEC; v++) begin
            l2h_bell = TBL[v].l2h;
            h2l_bell = TBL[v].h2l;
            mst_abort = TBL[v].mst;
            tgt_abort = TBL[v].tgt;
            lint_in_n = TBL[v].lin_n;
            dma_sel = TBL[v].sel;
            bist_en = TBL[v].bist;
            wr_word(TBL[v].wdata);
            chk($sformatf("R2/R3/R4/R5/R6/R8 word v%0d", v), reg_rdata, TBL[v].exp_rd);
            tick();
            chk($sformatf("R9 host v%0d", v), {31'b0, host_irq_n}, {31'b0, TBL[v].exp_host_n});
            chk($sformatf("R9 local v%0d", v), {31'b0, lint_out_n}, {31'b0, TBL[v].exp_lout_n});
        end

        // R5: releasing the local input drops the flag with no latch.
        l2h_bell = '0; h2l_bell = '0; mst_abort = 0; tgt_abort = 0; bist_en = 0;
        lint_in_n = 1'b0;
        wr_word(32'h0000_0900);
        chk("R5 set", reg_rdata, 32'h0000_8900);
        lint_in_n = 1'b1;
        tick();
        chk("R5 release word", reg_rdata, 32'h0000_0900);
        chk("R5 release host", {31'b0, host_irq_n}, 32'd1);

        // R7: DMA channel 0 set, route, clear.
        dma_sel = 2'b01;
        wr_word(32'h0005_0100);
        chk("R7 idle", reg_rdata, 32'h0005_0100);
        dma_done = 2'b01;
        tick();
        dma_done = 2'b00;
        chk("R7 pend0", reg_rdata, 32'h0025_0100);
        tick();
        chk("R7 host route", {30'b0, host_irq_n, lint_out_n}, 32'd1);
        dma_sel = 2'b00;
        tick();
        chk("R7 local route", {30'b0, host_irq_n, lint_out_n}, 32'd2);
        dma_clr = 2'b01;
        tick();
        dma_clr = 2'b00;
        chk("R7 cleared", reg_rdata, 32'h0005_0100);
        tick();
        chk("R7 local off", {31'b0, lint_out_n}, 32'd1);

        // R7: channel 1, clear wins over a simultaneous done.
        wr_word(32'h000D_0100);
        dma_done = 2'b10; dma_clr = 2'b10;
        tick();
        dma_done = 2'b00; dma_clr = 2'b00;
        chk("R7 clear priority", reg_rdata, 32'h000D_0100);
        dma_done = 2'b10;
        tick();
        dma_done = 2'b00;
        chk("R7 pend1", reg_rdata, 32'h004D_0100);
        tick();
        chk("R7 ch1 local", {30'b0, host_irq_n, lint_out_n}, 32'd2);
        dma_clr = 2'b11;
        tick();
        dma_clr = 2'b00;

        // R10: exact limit of 256 with limiting on.
        wr_word(32'h0000_1000);
        send_rsp(255, 1'b1, 4'd3, p);
        chk("R10 below limit", p, 0);
        send_rsp(1, 1'b1, 4'd3, p);
        chk("R10 at limit", p, 1);
        // R10: a non-retry response restarts the count.
        send_rsp(200, 1'b1, 4'd3, p);
        send_rsp(1, 1'b0, 4'd3, p);
        send_rsp(255, 1'b1, 4'd3, p);
        chk("R10 non-retry restart", p, 0);
        send_rsp(1, 1'b1, 4'd3, p);
        chk("R10 after restart", p, 1);
        // R10: a target change restarts at one.
        send_rsp(100, 1'b1, 4'd3, p);
        send_rsp(255, 1'b1, 4'd5, p);
        chk("R10 target change", p, 0);
        send_rsp(1, 1'b1, 4'd5, p);
        chk("R10 new target limit", p, 1);

        // R11: no abort when limiting is off.
        wr_word(32'h0000_0000);
        send_rsp(300, 1'b1, 4'd2, p);
        chk("R11 unlimited", p, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule